// File: doc/BRIEF.md
# Configurable Register Field with Access Side-Effects

This block holds one field of a control/status register as a single flop vector. Software reaches it through a byte-lane write bus with per-byte enables, plus a write strobe and a read strobe that the surrounding register decoder raises for the register that holds the field. Hardware reaches it through a value input and an optional load enable. The stored value goes straight from the flops to hardware. Bus decoding and the read-data multiplexer belong to the parent.

Parameters choose several things. They set what software and hardware may each do with the field and what a software write does to the stored bits: a plain load, set, clear or toggle on one, set, clear or toggle on zero, or force the whole field to zeros or to ones. They set whether a software read clears or sets the field and whether the field falls back to zero after one cycle. They set whether software or hardware wins when both update in the same cycle. They also set the reset style, the reset polarity and the reset value. The field's least significant bit may sit anywhere inside the bus word, so the field can start and end partway through a byte lane.

Top module: `regfield_cell`

## Requirements
- R1: While reset is active, the field holds RESET_VAL. Synchronous reset loads it on the clock edge. Asynchronous reset loads it without waiting for the clock. RST_HIGH sets the active level.
- R2: With a plain write, field bit k takes bus bit FIELD_LSB+k only when byte-enable bit (FIELD_LSB+k)/8 is set. Bits in disabled lanes keep their value. This holds even where the first or last lane covers only part of a byte.
- R3: For every bit in an enabled lane, set-on-one gives old|data, clear-on-one gives old&~data and toggle-on-one gives old^data.
- R4: For every bit in an enabled lane, set-on-zero gives old|~data, clear-on-zero gives old&data and toggle-on-zero gives old~^data.
- R5: With force-zeros or force-ones, any software write loads all zeros or all ones into the whole field, whatever the write data and the byte enables.
- R6: With read-clear or read-set, a read strobe loads all zeros or all ones into the field. If software has no read access, the read strobe leaves the field unchanged.
- R7: With software precedence, the update order is software write, then read side-effect, then hardware load. A hardware load that runs every cycle still loses to a software write.
- R8: With hardware precedence, a hardware load wins over a software write in the same cycle.
- R9: A hardware load takes hw_wdata only while hw_we is at its configured active level (high or low). With no enable configured, it loads every cycle.
- R10: In single-pulse mode, the field returns to zero in any cycle with no update, so a written value lasts exactly one cycle.
- R11: field_q comes directly from the flops. An update presented in one cycle appears after the next rising edge. With no update, the value holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Reset, polarity set by RST_HIGH |
| sw_wdata | input | BUS_W | Software write data word |
| sw_byte_en | input | BUS_W/8 | Per-byte write enables |
| sw_wr | input | 1 | Software write strobe for this register |
| sw_rd | input | 1 | Software read strobe for this register |
| hw_wdata | input | FIELD_W | Hardware load value |
| hw_we | input | 1 | Hardware load enable, polarity set by HW_WE |
| field_q | output | FIELD_W | Stored field value |

## Verification
The bench builds the block with a 12-bit field at bit 6 of a 32-bit bus, so the field has a two-bit slice in each of the two outer lanes and a full byte in the middle lane. It makes one instance for each write side-effect and drives them all from a shared table of data and byte-enable patterns. Further instances cover these settings: hardware precedence with an active-low enable and read-set; a free-running hardware load under software precedence; single-pulse mode; and a write-only field with read-clear and asynchronous active-low reset. Together they reach every arm of the priority chain, both enable polarities and the case where a read is ignored.

// File: rtl/regfield_pkg.sv
package regfield_pkg;

  typedef enum logic [1:0] {ACC_NA, ACC_RO, ACC_WO, ACC_RW} acc_e;

  typedef enum logic [3:0] {
    OW_PLAIN, OW_SET1, OW_CLR1, OW_TOG1,
    OW_SET0, OW_CLR0, OW_TOG0, OW_CLRALL, OW_SETALL
  } ow_e;

  typedef enum logic [1:0] {RD_NONE, RD_CLR, RD_SET} rd_e;

  typedef enum logic {PREC_SW, PREC_HW} prec_e;

  typedef enum logic [1:0] {HWE_NONE, HWE_HIGH, HWE_LOW} hwe_e;

  function automatic bit acc_can_wr(acc_e a);
    return (a == ACC_RW) || (a == ACC_WO);
  endfunction

  function automatic bit acc_can_rd(acc_e a);
    return (a == ACC_RW) || (a == ACC_RO);
  endfunction

endpackage

// File: rtl/regfield_sw_merge.sv
module regfield_sw_merge #(
  parameter int               BUS_W     = 32,
  parameter int               FIELD_W   = 12,
  parameter int               FIELD_LSB = 6,
  parameter regfield_pkg::ow_e ON_WR    = regfield_pkg::OW_PLAIN
) (
  input  logic [FIELD_W-1:0] old_q,
  input  logic [BUS_W-1:0]   bus_data,
  input  logic [BUS_W/8-1:0] byte_en,
  output logic [FIELD_W-1:0] new_q
);
  import regfield_pkg::*;

  for (genvar k = 0; k < FIELD_W; k++) begin : g_bit
    localparam int BPOS = FIELD_LSB + k;
    localparam int LANE = BPOS / 8;

    if (ON_WR == OW_CLRALL) begin : g_zero
      assign new_q[k] = 1'b0;
    end else if (ON_WR == OW_SETALL) begin : g_one
      assign new_q[k] = 1'b1;
    end else begin : g_lane
      logic d, o, m;
      assign d = bus_data[BPOS];
      assign o = old_q[k];
      always_comb begin
        case (ON_WR)
          OW_SET1: m = o | d;
          OW_CLR1: m = o & ~d;
          OW_TOG1: m = o ^ d;
          OW_SET0: m = o | ~d;
          OW_CLR0: m = o & d;
          OW_TOG0: m = o ~^ d;
          default: m = d;
        endcase
      end
      assign new_q[k] = byte_en[LANE] ? m : o;
    end
  end

endmodule

// File: rtl/regfield_hw_gate.sv
module regfield_hw_gate #(
  parameter regfield_pkg::hwe_e HW_WE = regfield_pkg::HWE_HIGH
) (
  input  logic we_in,
  output logic load_ok
);
  import regfield_pkg::*;

  if (HW_WE == HWE_HIGH) begin : g_high
    assign load_ok = we_in;
  end else if (HW_WE == HWE_LOW) begin : g_low
    assign load_ok = ~we_in;
  end else begin : g_free
    assign load_ok = 1'b1;
  end

endmodule

// File: rtl/regfield_next_sel.sv
module regfield_next_sel #(
  parameter int FIELD_W      = 12,
  parameter bit HW_FIRST     = 1'b0,
  parameter bit SINGLE_PULSE = 1'b0
) (
  input  logic [FIELD_W-1:0] cur_q,
  input  logic               sw_go,
  input  logic [FIELD_W-1:0] sw_val,
  input  logic               rd_go,
  input  logic [FIELD_W-1:0] rd_val,
  input  logic               hw_go,
  input  logic [FIELD_W-1:0] hw_val,
  output logic [FIELD_W-1:0] nxt_q
);

  always_comb begin
    if (HW_FIRST && hw_go)       nxt_q = hw_val;
    else if (sw_go)              nxt_q = sw_val;
    else if (rd_go)              nxt_q = rd_val;
    else if (!HW_FIRST && hw_go) nxt_q = hw_val;
    else if (SINGLE_PULSE)       nxt_q = '0;
    else                         nxt_q = cur_q;
  end

endmodule

// File: rtl/regfield_cell.sv
module regfield_cell #(
  parameter int                  BUS_W        = 32,
  parameter int                  FIELD_W      = 12,
  parameter int                  FIELD_LSB    = 6,
  parameter regfield_pkg::acc_e  SW_ACC       = regfield_pkg::ACC_RW,
  parameter regfield_pkg::acc_e  HW_ACC       = regfield_pkg::ACC_RW,
  parameter regfield_pkg::hwe_e  HW_WE        = regfield_pkg::HWE_HIGH,
  parameter regfield_pkg::ow_e   ON_WR        = regfield_pkg::OW_PLAIN,
  parameter regfield_pkg::rd_e   ON_RD        = regfield_pkg::RD_CLR,
  parameter regfield_pkg::prec_e PREC         = regfield_pkg::PREC_SW,
  parameter bit                  SINGLE_PULSE = 1'b0,
  parameter bit                  RST_ASYNC    = 1'b0,
  parameter bit                  RST_HIGH     = 1'b1,
  parameter logic [FIELD_W-1:0]  RESET_VAL    = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [BUS_W-1:0]   sw_wdata,
  input  logic [BUS_W/8-1:0] sw_byte_en,
  input  logic               sw_wr,
  input  logic               sw_rd,
  input  logic [FIELD_W-1:0] hw_wdata,
  input  logic               hw_we,
  output logic [FIELD_W-1:0] field_q
);
  import regfield_pkg::*;

  localparam bit SW_WR_OK = acc_can_wr(SW_ACC);
  localparam bit SW_RD_OK = acc_can_rd(SW_ACC) && (ON_RD != RD_NONE);
  localparam bit HW_WR_OK = acc_can_wr(HW_ACC);
  localparam bit HW_FIRST = (PREC == PREC_HW);

  if (FIELD_LSB + FIELD_W > BUS_W) begin : g_bad_span
    $error("regfield_cell: field does not fit inside the bus word");
  end
  if (HW_WR_OK && SW_WR_OK && HW_WE == HWE_NONE && HW_FIRST) begin : g_bad_cfg
    $error("regfield_cell: free-running hardware load with hardware precedence blocks every software write");
  end

  logic               rst_on;
  logic               hw_ok;
  logic               sw_go, rd_go, hw_go;
  logic [FIELD_W-1:0] sw_val, rd_val, nxt_q, q_r;

  assign rst_on = RST_HIGH ? rst : ~rst;

  regfield_sw_merge #(
    .BUS_W(BUS_W), .FIELD_W(FIELD_W), .FIELD_LSB(FIELD_LSB), .ON_WR(ON_WR)
  ) u_merge (
    .old_q(q_r), .bus_data(sw_wdata), .byte_en(sw_byte_en), .new_q(sw_val)
  );

  regfield_hw_gate #(.HW_WE(HW_WE)) u_gate (.we_in(hw_we), .load_ok(hw_ok));

  assign sw_go  = SW_WR_OK && sw_wr;
  assign rd_go  = SW_RD_OK && sw_rd;
  assign hw_go  = HW_WR_OK && hw_ok;
  assign rd_val = (ON_RD == RD_SET) ? '1 : '0;

  regfield_next_sel #(
    .FIELD_W(FIELD_W), .HW_FIRST(HW_FIRST), .SINGLE_PULSE(SINGLE_PULSE)
  ) u_sel (
    .cur_q(q_r), .sw_go(sw_go), .sw_val(sw_val), .rd_go(rd_go), .rd_val(rd_val),
    .hw_go(hw_go), .hw_val(hw_wdata), .nxt_q(nxt_q)
  );

  if (RST_ASYNC && RST_HIGH) begin : g_rst_ahi
    always_ff @(posedge clk or posedge rst) begin
      if (rst) q_r <= RESET_VAL;
      else     q_r <= nxt_q;
    end
  end else if (RST_ASYNC) begin : g_rst_alo
    always_ff @(posedge clk or negedge rst) begin
      if (!rst) q_r <= RESET_VAL;
      else      q_r <= nxt_q;
    end
  end else begin : g_rst_sync
    always_ff @(posedge clk) begin
      if (rst_on) q_r <= RESET_VAL;
      else        q_r <= nxt_q;
    end
  end

  assign field_q = q_r;

  // Assertions
  if (SINGLE_PULSE) begin : g_ast_pulse
    AST_PULSE_DROPS: assert property (@(posedge clk) disable iff (rst_on)
      (!sw_go && !rd_go && !hw_go) |=> (field_q == '0)); // R10
  end else begin : g_ast_hold
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst_on)
      (!sw_go && !rd_go && !hw_go) |=> $stable(field_q)); // R11
  end

  if (HW_WR_OK) begin : g_ast_hw
    AST_HW_LOAD: assert property (@(posedge clk) disable iff (rst_on)
      (hw_go && (HW_FIRST || (!sw_go && !rd_go))) |=> (field_q == $past(hw_wdata))); // R8
  end

  if (SW_RD_OK && ON_RD == RD_SET) begin : g_ast_rset
    AST_READ_SETS: assert property (@(posedge clk) disable iff (rst_on)
      (rd_go && !sw_go && !(HW_FIRST && hw_go)) |=> (&field_q)); // R6
  end else if (SW_RD_OK) begin : g_ast_rclr
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst_on)
      (rd_go && !sw_go && !(HW_FIRST && hw_go)) |=> (field_q == '0)); // R6
  end

  if (SW_WR_OK && ON_WR == OW_CLRALL) begin : g_ast_wclr
    AST_WRITE_ZEROES: assert property (@(posedge clk) disable iff (rst_on)
      (sw_go && !(HW_FIRST && hw_go)) |=> (field_q == '0)); // R5
  end else if (SW_WR_OK && ON_WR == OW_SETALL) begin : g_ast_wset
    AST_WRITE_ONES: assert property (@(posedge clk) disable iff (rst_on)
      (sw_go && !(HW_FIRST && hw_go)) |=> (&field_q)); // R5
  end

endmodule

// File: tb/regfield_cell_bench.sv
module regfield_cell_bench;
  import regfield_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int BW = 32;
  localparam int FW = 12;
  localparam int LSB = 6;
  localparam logic [FW-1:0] RV = 12'hA5C;
  localparam int NOW = 9;
  localparam ow_e OW_LIST [NOW] = '{OW_PLAIN, OW_SET1, OW_CLR1, OW_TOG1,
                                    OW_SET0, OW_CLR0, OW_TOG0, OW_CLRALL, OW_SETALL};

  typedef struct packed { logic [BW-1:0] d; logic [BW/8-1:0] be; } vec_t;
  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{32'h0003_FFC0, 4'b0111}, '{32'h0000_0000, 4'b0010},
    '{32'h0002_5540, 4'b0101}, '{32'h0001_AAC0, 4'b0110},
    '{32'hFFFF_FFFF, 4'b0001}, '{32'h0000_0000, 4'b0000},
    '{32'h1234_5678, 4'b1111}, '{32'h0002_0040, 4'b0100}};

  logic clk = 1'b0;
  logic rst, rst_n;
  logic [BW-1:0] sw_wdata;
  logic [BW/8-1:0] sw_be;
  logic sw_wr, sw_rd, hw_we_a, hwe_n_b;
  logic [FW-1:0] hw_wdata;
  logic [FW-1:0] q_main, q_hwprec, q_pulse, q_noread, q_hwfree;
  logic [FW-1:0] q_ow [NOW];

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign rst_n = ~rst;

  regfield_cell #(.ON_RD(RD_CLR), .RESET_VAL(RV)) u_regfield_cell (
    .clk(clk), .rst(rst), .sw_wdata(sw_wdata), .sw_byte_en(sw_be), .sw_wr(sw_wr),
    .sw_rd(sw_rd), .hw_wdata(hw_wdata), .hw_we(hw_we_a), .field_q(q_main));

  for (genvar t = 0; t < NOW; t++) begin : g_ow
    regfield_cell #(.HW_ACC(ACC_NA), .HW_WE(HWE_NONE), .ON_WR(OW_LIST[t]),
                    .ON_RD(RD_NONE), .RESET_VAL(RV)) u_ow (
      .clk(clk), .rst(rst), .sw_wdata(sw_wdata), .sw_byte_en(sw_be), .sw_wr(sw_wr),
      .sw_rd(sw_rd), .hw_wdata(hw_wdata), .hw_we(1'b0), .field_q(q_ow[t]));
  end

  regfield_cell #(.HW_WE(HWE_LOW), .PREC(PREC_HW), .ON_RD(RD_SET), .RESET_VAL(RV)) u_hwprec (
    .clk(clk), .rst(rst), .sw_wdata(sw_wdata), .sw_byte_en(sw_be), .sw_wr(sw_wr),
    .sw_rd(sw_rd), .hw_wdata(hw_wdata), .hw_we(hwe_n_b), .field_q(q_hwprec));

  regfield_cell #(.HW_ACC(ACC_NA), .HW_WE(HWE_NONE), .ON_RD(RD_NONE),
                  .SINGLE_PULSE(1'b1), .RESET_VAL(RV)) u_pulse (
    .clk(clk), .rst(rst), .sw_wdata(sw_wdata), .sw_byte_en(sw_be), .sw_wr(sw_wr),
    .sw_rd(sw_rd), .hw_wdata(hw_wdata), .hw_we(1'b0), .field_q(q_pulse));

  regfield_cell #(.SW_ACC(ACC_WO), .HW_ACC(ACC_NA), .HW_WE(HWE_NONE), .ON_RD(RD_CLR),
                  .RST_ASYNC(1'b1), .RST_HIGH(1'b0), .RESET_VAL(RV)) u_noread (
    .clk(clk), .rst(rst_n), .sw_wdata(sw_wdata), .sw_byte_en(sw_be), .sw_wr(sw_wr),
    .sw_rd(sw_rd), .hw_wdata(hw_wdata), .hw_we(1'b0), .field_q(q_noread));

  regfield_cell #(.HW_ACC(ACC_WO), .HW_WE(HWE_NONE), .ON_RD(RD_NONE), .RESET_VAL(RV)) u_hwfree (
    .clk(clk), .rst(rst), .sw_wdata(sw_wdata), .sw_byte_en(sw_be), .sw_wr(sw_wr),
    .sw_rd(sw_rd), .hw_wdata(hw_wdata), .hw_we(1'b0), .field_q(q_hwfree));

  function automatic logic [FW-1:0] model_wr(ow_e op, logic [FW-1:0] old,
                                             logic [BW-1:0] d, logic [BW/8-1:0] be);
    logic [FW-1:0] r;
    r = old;
    for (int k = 0; k < FW; k++) begin
      logic dk, ek;
      dk = d[LSB+k];
      ek = be[(LSB+k)/8];
      if (op == OW_CLRALL) r[k] = 1'b0;
      else if (op == OW_SETALL) r[k] = 1'b1;
      else if (ek) begin
        case (op)
          OW_SET1: r[k] = old[k] | dk;
          OW_CLR1: r[k] = old[k] & ~dk;
          OW_TOG1: r[k] = old[k] ^ dk;
          OW_SET0: r[k] = old[k] | ~dk;
          OW_CLR0: r[k] = old[k] & dk;
          OW_TOG0: r[k] = old[k] ~^ dk;
          default: r[k] = dk;
        endcase
      end
    end
    return r;
  endfunction

  function automatic string req_of(ow_e op);
    case (op)
      OW_PLAIN:                  return "R2";
      OW_SET1, OW_CLR1, OW_TOG1: return "R3";
      OW_SET0, OW_CLR0, OW_TOG0: return "R4";
      default:                   return "R5";
    endcase
  endfunction

  task automatic chk(string req, string what, logic [FW-1:0] act, logic [FW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [FW-1:0] exp [NOW];
    logic [FW-1:0] pre;
    rst = 1'b1; sw_wdata = '0; sw_be = '0; sw_wr = 1'b0; sw_rd = 1'b0;
    hw_we_a = 1'b0; hwe_n_b = 1'b1; hw_wdata = '0;
    tick(); tick(); tick();
    // R1: reset value in every style
    chk("R1", "main reset", q_main, RV);
    chk("R1", "pulse reset", q_pulse, RV);
    chk("R1", "async low reset", q_noread, RV);
    chk("R1", "hwprec reset", q_hwprec, RV);
    rst = 1'b0;
    tick();
    for (int t = 0; t < NOW; t++) exp[t] = RV;

    // Table walk: one write per vector, then one idle cycle
    for (int i = 0; i < NV; i++) begin
      sw_wdata = VECS[i].d; sw_be = VECS[i].be; sw_wr = 1'b1;
      tick();
      sw_wr = 1'b0;
      for (int t = 0; t < NOW; t++) begin
        exp[t] = model_wr(OW_LIST[t], exp[t], VECS[i].d, VECS[i].be);
        chk(req_of(OW_LIST[t]), OW_LIST[t].name(), q_ow[t], exp[t]);
      end
      chk("R2", "main plain write", q_main, exp[0]);
      chk("R10", "pulse high cycle", q_pulse, model_wr(OW_PLAIN, '0, VECS[i].d, VECS[i].be));
      tick();
      chk("R10", "pulse back to zero", q_pulse, '0);
      chk("R11", "main holds when idle", q_main, exp[0]);
    end

    // R6: read side-effects, and a read ignored without read access
    pre = exp[0];
    sw_rd = 1'b1;
    tick();
    sw_rd = 1'b0;
    chk("R6", "read clears", q_main, '0);
    chk("R6", "read sets", q_hwprec, 12'hFFF);
    chk("R6", "read ignored on write-only", q_noread, pre);

    // R7 / R11: all three sources at once under software precedence
    sw_wdata = 32'h0000_F140; sw_be = 4'b0111; sw_wr = 1'b1; sw_rd = 1'b1;
    hw_we_a = 1'b1; hw_wdata = 12'h111;
    #1;
    chk("R11", "no change before edge", q_main, '0);
    tick();
    chk("R7", "sw write beats read and hw", q_main, 12'h3C5);
    sw_wr = 1'b0;
    tick();
    chk("R7", "read beats hw", q_main, '0);
    sw_rd = 1'b0;
    tick();
    chk("R9", "hw load with high enable", q_main, 12'h111);
    hw_we_a = 1'b0; hw_wdata = 12'h222;
    tick();
    chk("R9", "hw gated off", q_main, 12'h111);

    // R8 / R9: hardware precedence with active-low enable
    hwe_n_b = 1'b0; hw_wdata = 12'h2B7; sw_wr = 1'b1;
    tick();
    chk("R8", "hw beats sw write", q_hwprec, 12'h2B7);
    hwe_n_b = 1'b1;
    tick();
    chk("R9", "low enable idle lets sw write", q_hwprec, 12'h3C5);
    hwe_n_b = 1'b0; sw_wr = 1'b0; hw_wdata = 12'h0F0;
    tick();
    chk("R9", "low enable loads", q_hwprec, 12'h0F0);
    hwe_n_b = 1'b1; hw_wdata = 12'h5A5;
    tick();
    chk("R9", "low enable deasserted holds", q_hwprec, 12'h0F0);
    chk("R9", "free-running hw load", q_hwfree, 12'h5A5);
    sw_wr = 1'b1;
    tick();
    sw_wr = 1'b0;
    chk("R7", "sw write beats free-running hw", q_hwfree, 12'h3C5);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule